// File: doc/BRIEF.md
# Single-Entry Exclusive Reservation Monitor

This block keeps one reserved physical address on behalf of a processor so that a load-exclusive / store-exclusive pair can form an atomic read-modify-write. A load-exclusive presents its physical address (the translated page bits joined with the low two byte-offset bits of the virtual address, so the byte offset takes part in the match). The monitor stores that address as its only tag and marks the reservation open. Any earlier reservation is overwritten.

A later store-exclusive presents its own physical address. In the same cycle the monitor answers with a status bit and a memory write enable. The store passes only when the address equals the tag and the reservation is open. A pass returns status 0, allows the memory write and empties the monitor. A fail returns status 1 and blocks the write. A failed store is not a fault; the status bit is the only result. A clear input empties the monitor in one cycle. When a load and a store arrive together, the store is judged against the old tag and then the load installs its new one.

Top module: `excl_monitor`

## Requirements
- R1: After reset the tag holds the all-ones value (the empty marker) and the open flag is 0, so a store-exclusive to any address fails.
- R2: A load-exclusive replaces the tag with its address and sets the open flag, whatever was reserved before; a later store to the earlier address fails.
- R3: A store-exclusive passes (st_fail = 0) in the cycle it is presented only when its address equals the tag and the open flag is 1; address matching uses every bit, including the two low byte-offset bits.
- R4: A passing store raises mem_wr_en in the same cycle, and from the next cycle the monitor is empty (a repeated store to the same address fails).
- R5: A failing store gives st_fail = 1 with mem_wr_en = 0 and leaves the reservation unchanged.
- R6: st_fail and mem_wr_en are 0 in any cycle without a store-exclusive.
- R7: The clear input empties the monitor for the next cycle; it takes priority over a load in the same cycle.
- R8: With a load and a store in the same cycle, the store result uses the old tag and open flag, and afterwards the load's address is reserved and open.
- R9: A load-exclusive to the all-ones address never yields a passing store, since that value marks an empty monitor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Empty the monitor |
| ld_vld | input | 1 | Load-exclusive present |
| ld_addr | input | ADDR_W | Physical address of the load-exclusive |
| st_vld | input | 1 | Store-exclusive present |
| st_addr | input | ADDR_W | Physical address of the store-exclusive |
| st_fail | output | 1 | Store status: 0 pass, 1 fail (valid while st_vld) |
| mem_wr_en | output | 1 | Permit the memory write of the store |

## Verification
Stores are tried against an empty monitor, against a matching open tag, against tags differing only in the byte-offset bits, and against a tag overwritten by a later load; these tell an exact full-width compare apart from a partial one and a single tag apart from a history. Back-to-back stores to the same address separate a clearing pass from a sticky one. Simultaneous load and store, clear with load, and a load of the empty marker probe the ordering and priority rules. A pseudo-random phase is compared each cycle against a behavioural model.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
    typedef struct packed {
        logic [31:0] tag;
        logic        open;
    } mon_state_t;
endpackage

// File: rtl/excl_match.sv
module excl_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] tag,
    input  logic              open,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] EMPTY = '1;
    always_comb begin
        hit = open && (tag == addr) && (tag != EMPTY);
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_fail,
    output logic              mem_wr_en
);
    localparam logic [ADDR_W-1:0] EMPTY = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic              open;
    } state_t;

    state_t s_d, s_q;
    logic   hit;

    excl_match #(.ADDR_W(ADDR_W)) u_match (
        .tag (s_q.tag),
        .open(s_q.open),
        .addr(st_addr),
        .hit (hit)
    );

    always_comb begin
        s_d       = s_q;
        st_fail   = 1'b0;
        mem_wr_en = 1'b0;
        if (st_vld) begin
            st_fail   = !hit;
            mem_wr_en = hit;
            if (hit) begin
                s_d.tag  = EMPTY;
                s_d.open = 1'b0;
            end
        end
        if (ld_vld) begin
            s_d.tag  = ld_addr;
            s_d.open = 1'b1;
        end
        if (clr_all) begin
            s_d.tag  = EMPTY;
            s_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tag  <= EMPTY;
            s_q.open <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_vld |-> (!st_fail && !mem_wr_en));
    assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |-> (st_fail != mem_wr_en));
    assert_pass_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !ld_vld) |=> !s_q.open);
    assert_load_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld && !clr_all) |=> (s_q.open && s_q.tag == $past(ld_addr)));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!s_q.open && s_q.tag == EMPTY));
    assert_fail_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && st_fail && !ld_vld && !clr_all) |=> $stable(s_q));
    assert_pass_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (st_addr == s_q.tag && s_q.open));
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_all = 1'b0, ld_vld = 1'b0, st_vld = 1'b0;
    logic [31:0] ld_addr = '0, st_addr = '0;
    logic        st_fail, mem_wr_en;

    int checks = 0, fails = 0;
    logic [31:0] m_tag = 32'hFFFF_FFFF;
    bit          m_open = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    excl_monitor #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .ld_vld(ld_vld),
        .ld_addr(ld_addr), .st_vld(st_vld), .st_addr(st_addr),
        .st_fail(st_fail), .mem_wr_en(mem_wr_en)
    );

    // Drive inputs on the falling edge, compare and update model before rise.
    task automatic step(input bit c, input bit l, input logic [31:0] la,
                        input bit s, input logic [31:0] sa, input string req);
        bit exp_fail, exp_wr, pass;
        @(negedge clk);
        clr_all = c; ld_vld = l; ld_addr = la; st_vld = s; st_addr = sa;
        #1;
        pass = s && m_open && (m_tag == sa) && (m_tag != 32'hFFFF_FFFF);
        exp_fail = s && !pass;
        exp_wr   = pass;
        checks++;
        if (st_fail !== exp_fail || mem_wr_en !== exp_wr) begin
            fails++;
            $display("FAIL %s: fail/wr = %b/%b expected %b/%b", req,
                     st_fail, mem_wr_en, exp_fail, exp_wr);
        end
        if (pass) begin m_tag = 32'hFFFF_FFFF; m_open = 0; end
        if (l) begin m_tag = la; m_open = 1; end
        if (c) begin m_tag = 32'hFFFF_FFFF; m_open = 0; end
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #20000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle("R1 reset quiet");
        step(0, 0, 0, 1, 32'h0, "R1 store after reset fails");
        step(0, 0, 0, 1, 32'hFFFF_FFFF, "R1 empty marker store fails");
        step(0, 1, 32'h1000_0004, 0, 0, "R2 load");
        idle("R6 no store quiet");
        step(0, 0, 0, 1, 32'h1000_0005, "R3 offset bit differs fails");
        step(0, 0, 0, 1, 32'h1000_0006, "R3 offset bit1 differs fails");
        step(0, 0, 0, 1, 32'h1000_0004, "R3 match passes R4");
        step(0, 0, 0, 1, 32'h1000_0004, "R4 repeat store fails");
        step(0, 1, 32'hA, 0, 0, "R2 load A");
        step(0, 1, 32'hB, 0, 0, "R2 load B overwrites");
        step(0, 0, 0, 1, 32'hA, "R2 old address fails");
        step(0, 0, 0, 1, 32'hB, "R5 reservation kept after fail");
        step(0, 1, 32'hC, 0, 0, "R7 load");
        step(1, 0, 0, 0, 0, "R7 clear");
        step(0, 0, 0, 1, 32'hC, "R7 store after clear fails");
        step(1, 1, 32'hD, 0, 0, "R7 clear beats load");
        step(0, 0, 0, 1, 32'hD, "R7 store after clear+load fails");
        step(0, 1, 32'hE, 0, 0, "R8 setup");
        step(0, 1, 32'hF, 1, 32'hE, "R8 store uses old tag passes");
        step(0, 0, 0, 1, 32'hF, "R8 new tag installed");
        step(0, 1, 32'h20, 1, 32'h21, "R8 fail with load");
        step(0, 0, 0, 1, 32'h20, "R8 load after fail");
        step(0, 1, 32'hFFFF_FFFF, 0, 0, "R9 load empty marker");
        step(0, 0, 0, 1, 32'hFFFF_FFFF, "R9 store empty marker fails");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            step(r[0] & r[1] & r[2], r[3], {30'h0, r[9:8]},
                 r[4], {30'h0, r[11:10]}, "R3 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule